// File: doc/BRIEF.md
# Watchdog Timer with Prescaler and Guarded Control Register

This block is a watchdog for a small microcontroller. It counts enable pulses from a slow on-chip oscillator through a selectable prescaler into a 64-step time-out counter. If software does not zero the count in time, the block raises a one-clock system reset request. The same cycle also stands for the watchdog reset itself: the block records that it was the cause and restores its register fields as that reset type requires.

Software reaches the block through an 8-bit control register. A write to that register takes effect only inside a short window that a two-byte unlock sequence opens on a separate access port. Fields survive resets in different ways. Power-on clears everything. An ordinary reset reloads only the enable. A watchdog reset reloads the enable and sets the cause flag. The enable always comes from the inverse of a non-volatile configuration input, and a 0 on that input means the watchdog runs.

Top module: `wdg_top`

## Requirements
- R1: During power-on reset (`por_n` low) `ctl_rdata` reads 0x00 and `rst_req` is low. One clock after release, bit 7 reads the inverse of `cfg_wdt_off` and every other bit reads 0.
- R2: A cycle with `ext_rst` high reloads bit 7 from the inverse of `cfg_wdt_off` and zeroes the count. It leaves bit 4, bit 3 and bits 2:0 unchanged.
- R3: A control write (`ctl_wr`) is accepted only if `acc_wr` carried 0xAA in one cycle and 0x55 in the next, and the control write falls in one of the 3 cycles right after the 0x55 cycle. Only the first control write in a window is accepted. Any other control write leaves the register unchanged.
- R4: An accepted write with bit 6 set zeroes the time-out count and the prescaler, so a full interval restarts from that cycle.
- R5: The prescaler select in bits 2:0 picks a divide ratio: code 0 gives 1, and code c from 1 to 7 gives 2^(c+1), which is 4 through 256. With `osc_tick` high every cycle, `rst_req` rises 64×ratio clocks after the cycle that cleared the count.
- R6: On time-out `rst_req` is high for exactly one clock. In that same clock bit 3 (reset cause) becomes 1, bit 7 reloads from the inverse of `cfg_wdt_off`, and bits 4 and 2:0 are kept. An accepted write loads bit 3 from write data bit 3, which lets software clear it with a 0.
- R7: With bit 4 = 0, the count holds while `cpu_sleep` is high. With bit 4 = 1, it keeps counting while `cpu_sleep` is high.
- R8: With bit 7 = 0 the count and the prescaler stay at zero and `rst_req` never rises.
- R9: Bits 6 and 5 always read 0, whatever was written to them.
- R10: Only cycles with `osc_tick` high advance the prescaler. While `osc_tick` stays low, no time-out occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | Synchronous non-power-on reset, active high |
| cfg_wdt_off | input | 1 | Configuration bit; 0 means the watchdog is enabled after any reset |
| osc_tick | input | 1 | One-cycle enable pulse from the slow oscillator |
| cpu_sleep | input | 1 | CPU is in idle or power-down |
| acc_wr | input | 1 | Write strobe for the unlock access port |
| ctl_wr | input | 1 | Write strobe for the control register |
| wdata | input | 8 | Write data shared by both ports |
| ctl_rdata | output | 8 | Control register read value: {enable, 0, 0, run-in-sleep, cause, select[2:0]} |
| rst_req | output | 1 | One-clock system reset request on time-out |

## Verification
The bench goes after the edges of the unlock window. A write one cycle too late, or a second write in the same window, must leave the register unchanged. A design that counted the window off by one, or kept it open after a write, would take the change. The bench times the interval exactly for several prescaler codes, including the largest. A wrong divide table or a counter off by one shows up as a time-out several clocks early or late. It also checks which fields survive an ordinary reset and a watchdog reset, and that the count holds in sleep. A design that cleared the select on an ordinary reset, or kept counting with bit 4 = 0, would read back the wrong value or time out during a quiet window.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CTL_W    = 8;
    localparam int SEL_W    = 3;
    localparam int PS_W     = 8;

    localparam int B_EN     = 7;
    localparam int B_CLR    = 6;
    localparam int B_SLEEP  = 4;
    localparam int B_CAUSE  = 3;

    typedef struct packed {
        logic             en;
        logic             sleep_run;
        logic             cause;
        logic [SEL_W-1:0] sel;
    } wdg_ctl_t;

    // Terminal value (ratio - 1) of the prescaler for a select code.
    function automatic logic [PS_W-1:0] ps_last(input logic [SEL_W-1:0] code);
        logic [PS_W:0] ratio;
        logic [PS_W:0] last;
        ratio = (code == '0) ? (PS_W+1)'(1) : ((PS_W+1)'(2) << code);
        last  = ratio - (PS_W+1)'(1);
        return last[PS_W-1:0];
    endfunction

    function automatic logic [CTL_W-1:0] ctl_pack(input wdg_ctl_t c);
        logic [CTL_W-1:0] r;
        r          = '0;
        r[B_EN]    = c.en;
        r[B_SLEEP] = c.sleep_run;
        r[B_CAUSE] = c.cause;
        r[SEL_W-1:0] = c.sel;
        return r;
    endfunction

endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock #(
    parameter int          DATA_W = 8,
    parameter int          WIN    = 3,
    parameter logic [7:0]  KEY_A  = 8'hAA,
    parameter logic [7:0]  KEY_B  = 8'h55
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              ctl_wr,
    output logic              ctl_ok
);
    localparam int WIN_W = $clog2(WIN + 1);

    typedef struct packed {
        logic             armed;
        logic [WIN_W-1:0] win;
    } ul_state_t;

    ul_state_t st_d, st_q;
    logic      win_open;

    always_comb begin
        st_d     = st_q;
        win_open = (st_q.win != '0);
        ctl_ok   = ctl_wr && win_open;

        st_d.armed = acc_wr && (acc_data == DATA_W'(KEY_A));

        if (acc_wr && st_q.armed && (acc_data == DATA_W'(KEY_B))) begin
            st_d.win = WIN_W'(WIN);
        end else if (win_open) begin
            st_d.win = st_q.win - WIN_W'(1);
        end

        if (ctl_ok) begin
            st_d.win = '0;
        end

        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: one accepted write closes the window
    p_single_write_r3: assert property (@(posedge clk) disable iff (!por_n)
        ctl_ok |=> (st_q.win == '0));

endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr,
    input  logic             run,
    input  logic             osc_tick,
    input  logic [SEL_W-1:0] code,
    output logic             tick_o
);
    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } ps_state_t;

    ps_state_t       st_d, st_q;
    logic [PS_W-1:0] last;
    logic            step;

    always_comb begin
        st_d   = st_q;
        last   = ps_last(code);
        step   = run && osc_tick && !clr;
        tick_o = step && (st_q.cnt >= last);

        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = tick_o ? '0 : (st_q.cnt + PS_W'(1));
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: every divided tick restarts the prescaler count
    p_tick_restart_r5: assert property (@(posedge clk) disable iff (!por_n)
        tick_o |=> (st_q.cnt == '0));

    // R10: no divided tick without an oscillator pulse
    p_tick_needs_osc_r10: assert property (@(posedge clk) disable iff (!por_n)
        !osc_tick |=> $stable(st_q.cnt) || (st_q.cnt == '0));

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int TICKS = 64
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     clr,
    input  logic                     tick,
    output logic [$clog2(TICKS)-1:0] count_o,
    output logic                     timeout_o
);
    localparam int CW = $clog2(TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ct_state_t;

    ct_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        timeout_o = tick && !clr && (st_q.cnt == CW'(TICKS - 1));

        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = timeout_o ? '0 : (st_q.cnt + CW'(1));
        end
    end

    assign count_o = st_q.cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the count restarts after a time-out
    p_wrap_after_timeout_r6: assert property (@(posedge clk) disable iff (!por_n)
        timeout_o |=> (st_q.cnt == '0));

endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int TICKS = 64,
    parameter int WIN   = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ext_rst,
    input  logic             cfg_wdt_off,
    input  logic             osc_tick,
    input  logic             cpu_sleep,
    input  logic             acc_wr,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             rst_req
);
    localparam int CW = $clog2(TICKS);

    typedef struct packed {
        wdg_ctl_t ctl;
        logic     boot;
        logic     req;
    } top_state_t;

    top_state_t    st_d, st_q;
    logic          wr_ok;
    logic          to_hit;
    logic          soft_rst;
    logic          div_tick;
    logic          run;
    logic          zero_all;
    logic [CW-1:0] wd_count;

    wdg_unlock #(
        .DATA_W (CTL_W),
        .WIN    (WIN)
    ) u_unlock (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .acc_wr   (acc_wr),
        .acc_data (wdata),
        .ctl_wr   (ctl_wr),
        .ctl_ok   (wr_ok)
    );

    wdg_prescale u_ps (
        .clk      (clk),
        .por_n    (por_n),
        .clr      (zero_all),
        .run      (run),
        .osc_tick (osc_tick),
        .code     (st_q.ctl.sel),
        .tick_o   (div_tick)
    );

    wdg_counter #(
        .TICKS (TICKS)
    ) u_cnt (
        .clk       (clk),
        .por_n     (por_n),
        .clr       (zero_all),
        .tick      (div_tick),
        .count_o   (wd_count),
        .timeout_o (to_hit)
    );

    always_comb begin
        st_d     = st_q;
        run      = st_q.ctl.en && (!cpu_sleep || st_q.ctl.sleep_run);
        soft_rst = ext_rst || to_hit;
        zero_all = ext_rst || !st_q.ctl.en || (wr_ok && wdata[B_CLR]);
        st_d.req = to_hit && !ext_rst;
        st_d.boot = 1'b0;

        if (st_q.boot) begin
            st_d.ctl.en = !cfg_wdt_off;
        end else if (ext_rst) begin
            st_d.ctl.en = !cfg_wdt_off;
        end else if (to_hit) begin
            st_d.ctl.en    = !cfg_wdt_off;
            st_d.ctl.cause = 1'b1;
        end else if (wr_ok) begin
            st_d.ctl.en        = wdata[B_EN];
            st_d.ctl.sleep_run = wdata[B_SLEEP];
            st_d.ctl.cause     = wdata[B_CAUSE];
            st_d.ctl.sel       = wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q      <= '0;
            st_q.boot <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_rdata = ctl_pack(st_q.ctl);
    assign rst_req   = st_q.req;

    // R6: the request lasts one clock
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    // R6: the cause flag is set whenever the request is up
    p_cause_on_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> ctl_rdata[B_CAUSE]);

    // R7: count holds in sleep when running in sleep is off
    p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.ctl.en && cpu_sleep && !st_q.ctl.sleep_run && !ext_rst && !wr_ok && !st_q.boot)
            |=> $stable(wd_count));

    // R8: a disabled watchdog produces no divided tick
    p_off_no_tick_r8: assert property (@(posedge clk) disable iff (!por_n)
        !st_q.ctl.en |-> !div_tick);

    // R9: unused bits never read as 1
    p_zero_bits_r9: assert property (@(posedge clk) disable iff (!por_n)
        ctl_rdata[6:5] == 2'b00);

endmodule

// File: tb/tb_wdg_top.sv
`timescale 1ns/1ps
module tb_wdg_top;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst = 1'b0;
    logic       cfg_wdt_off = 1'b1;
    logic       osc_tick = 1'b1;
    logic       cpu_sleep = 1'b0;
    logic       acc_wr = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] val;
        int         due;
    } exp_t;

    exp_t sbq[$];

    always #5 clk = ~clk;

    wdg_top dut (
        .clk         (clk),
        .por_n       (por_n),
        .ext_rst     (ext_rst),
        .cfg_wdt_off (cfg_wdt_off),
        .osc_tick    (osc_tick),
        .cpu_sleep   (cpu_sleep),
        .acc_wr      (acc_wr),
        .ctl_wr      (ctl_wr),
        .wdata       (wdata),
        .ctl_rdata   (ctl_rdata),
        .rst_req     (rst_req)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic note(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compares queued expectations against the register read port
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            note(e.req, int'(ctl_rdata), int'(e.val));
        end
    end

    // Driver side of the scoreboard
    task automatic expect_rd(input string req, input logic [7:0] v);
        exp_t e;
        e.req = req;
        e.val = v;
        e.due = cyc + 1;
        sbq.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic unlock_then(input int gap, input logic [7:0] d, input bit second,
                               input logic [7:0] d2);
        @(negedge clk); acc_wr = 1'b1; wdata = 8'hAA;
        @(negedge clk); wdata = 8'h55;
        @(negedge clk); acc_wr = 1'b0;
        for (int i = 0; i < gap; i++) @(negedge clk);
        ctl_wr = 1'b1; wdata = d;
        if (second) begin
            @(negedge clk); wdata = d2;
        end
        @(negedge clk); ctl_wr = 1'b0; wdata = 8'h00;
    endtask

    task automatic prot_write(input logic [7:0] d);
        unlock_then(0, d, 1'b0, 8'h00);
    endtask

    task automatic measure(input string req, input int exp);
        int n;
        n = 0;
        while (rst_req !== 1'b1 && n < exp + 20) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        note(req, n, exp);
        @(negedge clk);
        note({req, " pulse width"}, int'(rst_req), 0);
    endtask

    task automatic quiet(input string req, input int cycles);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        note(req, seen, 0);
    endtask

    task automatic pulse_ext;
        @(negedge clk); ext_rst = 1'b1;
        @(negedge clk); ext_rst = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        note("R1 rdata in reset", int'(ctl_rdata), 8'h00);
        note("R1 rst_req in reset", int'(rst_req), 0);
        por_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        expect_rd("R1 after release cfg=1", 8'h00);

        // R3: unguarded write ignored
        @(negedge clk); ctl_wr = 1'b1; wdata = 8'h97;
        @(negedge clk); ctl_wr = 1'b0;
        expect_rd("R3 write without unlock", 8'h00);
        // R3: write one cycle past the window
        unlock_then(3, 8'h97, 1'b0, 8'h00);
        expect_rd("R3 write after window", 8'h00);

        // R4 R5 R9: clear + enable, select 1 -> ratio 4
        prot_write(8'hC1);
        measure("R5 code1 interval", 256);
        // R6: cause set, enable reloaded from cfg=1 (off), select kept
        expect_rd("R6 after timeout", 8'h09);
        // R2: ordinary reset keeps cause and select
        pulse_ext;
        expect_rd("R2 ext reset keeps fields", 8'h09);

        cfg_wdt_off = 1'b0;
        // R9 R6: reserved bit written, cause cleared by writing 0, select 2
        prot_write(8'hE2);
        expect_rd("R9 reserved reads 0", 8'h82);
        prot_write(8'hC2);
        measure("R5 code2 interval", 512);

        // R3: second write in one window is ignored
        unlock_then(0, 8'hC0, 1'b1, 8'hC7);
        expect_rd("R3 second write ignored", 8'h80);

        // R7: halt in sleep
        prot_write(8'hC0);
        cpu_sleep = 1'b1;
        quiet("R7 halted in sleep", 300);
        cpu_sleep = 1'b0;
        measure("R7 resume after sleep", 64);
        // R7: keep running in sleep
        prot_write(8'hD0);
        cpu_sleep = 1'b1;
        measure("R7 runs in sleep", 64);
        cpu_sleep = 1'b0;

        // R10: no oscillator pulses, no progress
        prot_write(8'hC0);
        osc_tick = 1'b0;
        quiet("R10 no osc ticks", 300);
        osc_tick = 1'b1;
        measure("R10 resume with ticks", 64);

        // R8: disabled
        prot_write(8'h00);
        quiet("R8 disabled quiet", 400);
        expect_rd("R8 disabled readback", 8'h00);

        // R2: ordinary reset reloads enable only
        prot_write(8'h13);
        expect_rd("R2 written", 8'h13);
        pulse_ext;
        expect_rd("R2 enable from cfg=0", 8'h93);
        cfg_wdt_off = 1'b1;
        pulse_ext;
        expect_rd("R2 enable from cfg=1", 8'h13);

        // R1: power-on clears all
        cfg_wdt_off = 1'b0;
        @(negedge clk); por_n = 1'b0;
        @(negedge clk);
        note("R1 por clears", int'(ctl_rdata), 8'h00);
        por_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        expect_rd("R1 after release cfg=0", 8'h80);

        // R5: largest ratio
        prot_write(8'hC7);
        measure("R5 code7 interval", 16384);

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule